// File: doc/BRIEF.md
# Complementary PWM Gate Driver with Dead Time and Fault Latch

This block produces one edge-aligned pulse-width-modulated phase for a half-bridge. A free-running counter sweeps from zero up to a programmed period and restarts, and a reference waveform is high while the count is below a duty value. The period and duty values are taken into internal shadow copies only when the counter wraps. A change in the middle of a period therefore never produces a cut-short or doubled pulse.

The reference drives a pair of complementary gate outputs, one for the high-side switch and one for the low-side switch. A programmable guard interval holds each output off for a number of cycles after every reference edge, so the two switches are never on together. A pulse that is too short to outlast the guard interval produces no active level at all.

An external break input passes through a two-flop synchronizer and sets a latched fault. The fault forces both gates low and stays set until software pulses an acknowledge while the synchronized break is low. The output enable also forces both gates low. Whenever the gates are released, by acknowledge or by enable, each gate waits the full guard interval before it turns on.

Top module: `cpwm_gate`

## Requirements
- R1: The counter runs 0,1,…,P and then returns to 0, so one period lasts P+1 cycles. P is the shadowed period. The period and duty inputs are copied into the shadows only in the cycle in which the counter equals the shadowed period. Reset clears the counter and both shadows, so the first clock loads them.
- R2: The reference is high in every cycle whose count is below the shadowed duty C. It is therefore high for C cycles of each period. C=0 keeps it low, and C>P keeps it high for the whole period.
- R3: The low-side gate is active only while the reference is low, and the high-side gate only while it is high. gate_hi and gate_lo are never 1 in the same cycle.
- R4: Let L(t) be the number of consecutive unblocked cycles, ending at cycle t, in which the reference has held its current value. A gate becomes active one cycle after a cycle t in which its reference level holds and L(t) > dead_cnt. With dead_cnt=0 each gate follows its reference level one cycle late.
- R5: A reference level lasting W cycles gives its gate W−dead_cnt active cycles if W > dead_cnt, and none otherwise.
- R6: A break input held high sets flt_stat, and drives both gates low, at the third rising clock edge after it rises. The delay comes from two synchronizer flops and the fault flop.
- R7: Once set, flt_stat stays 1 until flt_ack is 1 at an edge while the synchronized break is 0. An acknowledge seen while the synchronized break is 1 has no effect, and the fault never clears by itself.
- R8: A cycle that is blocked (fault latched or out_en low) restarts L. After the gates are released, each gate waits the full dead time before it turns on.
- R9: While out_en is 0, both gates are 0 in that same cycle.
- R10: During and right after reset, gate_hi, gate_lo and flt_stat are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | CNT_W | Last count value of a period; loaded at wrap |
| duty | input | CNT_W | Number of high reference cycles per period; loaded at wrap |
| dead_cnt | input | DT_W | Guard interval in cycles |
| out_en | input | 1 | 1 lets the gates drive; 0 forces both low |
| brk_in | input | 1 | Asynchronous break request, active high |
| flt_ack | input | 1 | Fault acknowledge strobe |
| gate_hi | output | 1 | High-side switch gate, active high |
| gate_lo | output | 1 | Low-side switch gate, active high |
| flt_stat | output | 1 | Latched fault flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a duty or period write and the counter wrap that loads the shadows. The second pair is the fault acknowledge and a new break arriving in the same cycle. The bench changes duty at arbitrary phases, including exactly on the wrap cycle. It also raises the break and pulses the acknowledge on the same clock edge, both with the fault clear and with the fault set while the synchronized break is still low. A behavioural model in the bench tracks reference run lengths with plain integers and judges both outputs and the flag on every cycle. In the collision cases it expects the acknowledge to clear the fault and the new break to set it again two edges later.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int CPWM_CNT_W = 8;
    localparam int CPWM_DT_W  = 4;

    typedef struct packed {
        logic sync1;
        logic sync2;
        logic latched;
    } flt_state_t;

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
    parameter int CNT_W = cpwm_pkg::CPWM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    output logic             ref_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] dut;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == st_q.per);
        if (wrap) begin
            st_d.cnt = '0;
            st_d.per = period;
            st_d.dut = duty;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        ref_o = (st_q.cnt < st_q.dut);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: the count never passes the shadowed period
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.per);

    // R1: the shadows move only on the wrap cycle
    assert_shadow_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != st_q.per) |=> ($stable(st_q.dut) && $stable(st_q.per)));

endmodule

// File: rtl/cpwm_fault.sv
module cpwm_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_i,
    input  logic ack_i,
    output logic flt_o
);

    cpwm_pkg::flt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = brk_i;
        st_d.sync2 = st_q.sync1;
        if (st_q.latched) st_d.latched = !(ack_i && !st_q.sync2);
        else              st_d.latched = st_q.sync2;
        flt_o = st_q.latched;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: no acknowledge, no release
    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latched && !ack_i) |=> st_q.latched);

    // R7: acknowledge ignored while the synchronized break is high
    assert_ack_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latched && st_q.sync2) |=> st_q.latched);

    // R6: a synchronized break always lands in the latch
    assert_break_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sync2 |=> st_q.latched);

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
    parameter int DT_W = cpwm_pkg::CPWM_DT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic            blk_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            hi_o,
    output logic            lo_o
);

    localparam logic [DT_W-1:0] RUN_MAX = {DT_W{1'b1}};

    typedef struct packed {
        logic [DT_W-1:0] run;
        logic            prev;
        logic            blkp;
        logic            hi;
        logic            lo;
    } db_state_t;

    db_state_t       st_d, st_q;
    logic            same;
    logic            open;
    logic [DT_W-1:0] len;

    always_comb begin
        st_d = st_q;
        same = (ref_i == st_q.prev) && !st_q.blkp;
        if (!same)                len = '0;
        else if (st_q.run == RUN_MAX) len = RUN_MAX;
        else                      len = st_q.run + 1'b1;
        open      = (len >= dead_i);
        st_d.run  = blk_i ? '0 : len;
        st_d.prev = ref_i;
        st_d.blkp = blk_i;
        st_d.hi   = !blk_i && ref_i && open;
        st_d.lo   = !blk_i && !ref_i && open;
        hi_o      = st_q.hi;
        lo_o      = st_q.lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the pair never conducts together
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hi && st_q.lo));

    // R4: with a non-zero guard the high side cannot follow the low side at once
    assert_gap_lo_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lo && dead_i != '0) |=> !st_q.hi);

    // R4: and the reverse direction
    assert_gap_hi_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hi && dead_i != '0) |=> !st_q.lo);

endmodule

// File: rtl/cpwm_gate.sv
module cpwm_gate #(
    parameter int CNT_W = cpwm_pkg::CPWM_CNT_W,
    parameter int DT_W  = cpwm_pkg::CPWM_DT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic [DT_W-1:0]  dead_cnt,
    input  logic             out_en,
    input  logic             brk_in,
    input  logic             flt_ack,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic             flt_stat
);

    logic ref_w;
    logic flt_w;
    logic blk_w;
    logic hi_w;
    logic lo_w;

    cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period),
        .duty   (duty),
        .ref_o  (ref_w)
    );

    cpwm_fault u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .brk_i (brk_in),
        .ack_i (flt_ack),
        .flt_o (flt_w)
    );

    always_comb blk_w = flt_w || !out_en;

    cpwm_deadband #(.DT_W(DT_W)) u_db (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_w),
        .blk_i  (blk_w),
        .dead_i (dead_cnt),
        .hi_o   (hi_w),
        .lo_o   (lo_w)
    );

    always_comb begin
        gate_hi  = hi_w && !blk_w;
        gate_lo  = lo_w && !blk_w;
        flt_stat = flt_w;
    end

    // R6: a synchronized break shuts both gates from the cycle the flag sets
    assert_fault_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_stat) |-> (!gate_hi && !gate_lo));

    // R8: a release never turns a gate on in the very next cycle with a guard set
    assert_release_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_w && dead_cnt != '0) |=> (!hi_w && !lo_w));

endmodule

// File: tb/tb_cpwm_gate.sv
module tb_cpwm_gate;

    localparam int CNT_W = 8;
    localparam int DT_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] period = '0;
    logic [CNT_W-1:0] duty = '0;
    logic [DT_W-1:0]  dead_cnt = '0;
    logic             out_en = 1'b0;
    logic             brk_in = 1'b0;
    logic             flt_ack = 1'b0;
    logic             gate_hi, gate_lo, flt_stat;

    cpwm_gate #(.CNT_W(CNT_W), .DT_W(DT_W)) dut (
        .clk(clk), .rst_n(rst_n), .period(period), .duty(duty),
        .dead_cnt(dead_cnt), .out_en(out_en), .brk_in(brk_in),
        .flt_ack(flt_ack), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .flt_stat(flt_stat)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R10";

    // behavioural reference state
    int m_cnt, m_per, m_duty, m_run;
    bit m_s1, m_s2, m_flt, m_prevref, m_prevblk, m_hi, m_lo;
    int hi_seen, lo_seen;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_duty = 0; m_run = 0;
            m_s1 = 0; m_s2 = 0; m_flt = 0;
            m_prevref = 0; m_prevblk = 0; m_hi = 0; m_lo = 0;
        end else begin
            bit r, b, so;
            r = (m_cnt < m_duty);
            b = m_flt || !out_en;
            if (b) m_run = 0;
            else if (r == m_prevref && !m_prevblk) m_run = m_run + 1;
            else m_run = 1;
            m_prevref = r;
            m_prevblk = b;
            so = (m_run > int'(dead_cnt));
            m_hi = !b && r && so;
            m_lo = !b && !r && so;
            if (m_cnt == m_per) begin
                m_cnt = 0; m_per = int'(period); m_duty = int'(duty);
            end else m_cnt = m_cnt + 1;
            if (m_flt) m_flt = !(flt_ack && !m_s2);
            else       m_flt = m_s2;
            m_s2 = m_s1;
            m_s1 = brk_in;
        end
    end

    always @(posedge clk) begin
        #1;
        cycles++;
        if (rst_n && !done) begin
            bit blk_now;
            blk_now = m_flt || !out_en;
            check(cur_req, "gate_hi", gate_hi, m_hi && !blk_now);
            check(cur_req, "gate_lo", gate_lo, m_lo && !blk_now);
            check(cur_req, "flt_stat", flt_stat, m_flt);
            check("R3", "overlap", gate_hi && gate_lo, 0);
            if (gate_hi) hi_seen++;
            if (gate_lo) lo_seen++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(4);
        check("R10", "reset gate_hi", gate_hi, 0);
        check("R10", "reset gate_lo", gate_lo, 0);
        check("R10", "reset flt_stat", flt_stat, 0);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R10", "post-reset flt_stat", flt_stat, 0);

        cur_req = "R2"; period = 8'd9; duty = 8'd4; dead_cnt = 4'd0; out_en = 1'b1;
        wait_cyc(40);

        cur_req = "R1";
        duty = 8'd7; wait_cyc(13);
        duty = 8'd3; wait_cyc(1);
        duty = 8'd6; period = 8'd6; wait_cyc(30);

        cur_req = "R4"; period = 8'd9; duty = 8'd5; dead_cnt = 4'd2;
        wait_cyc(40);

        cur_req = "R5"; duty = 8'd2; dead_cnt = 4'd3;
        wait_cyc(12);
        hi_seen = 0; lo_seen = 0;
        wait_cyc(30);
        check("R5", "short high pulse suppressed", hi_seen, 0);
        check("R5", "low side 5 of 8 per period", lo_seen, 15);

        cur_req = "R2"; duty = 8'd0; dead_cnt = 4'd1; wait_cyc(30);
        duty = 8'd12; wait_cyc(30);

        cur_req = "R9"; duty = 8'd5; dead_cnt = 4'd1; wait_cyc(7);
        out_en = 1'b0; wait_cyc(1);
        check("R9", "gate_hi off", gate_hi, 0);
        check("R9", "gate_lo off", gate_lo, 0);
        wait_cyc(6);
        cur_req = "R8"; out_en = 1'b1; wait_cyc(25);

        cur_req = "R6"; dead_cnt = 4'd2;
        brk_in = 1'b1; flt_ack = 1'b1;       // break and ack on the same edge, fault clear
        @(negedge clk); flt_ack = 1'b0;
        @(negedge clk);
        @(posedge clk); #1;
        check("R6", "flag on third edge", flt_stat, 1);
        check("R6", "gates low on fault", gate_hi || gate_lo, 0);
        cur_req = "R7";
        wait_cyc(3); flt_ack = 1'b1; wait_cyc(1); flt_ack = 1'b0;
        wait_cyc(1);
        check("R7", "ack during break ignored", flt_stat, 1);
        brk_in = 1'b0; wait_cyc(8);
        check("R7", "no self clear", flt_stat, 1);
        // ack coincides with a new break while the synchronized break is low
        flt_ack = 1'b1; brk_in = 1'b1; wait_cyc(1); flt_ack = 1'b0;
        wait_cyc(1);
        check("R7", "ack clears", flt_stat, 0);
        wait_cyc(1);
        check("R6", "new break relatches", flt_stat, 1);
        brk_in = 1'b0; wait_cyc(4);
        cur_req = "R8"; flt_ack = 1'b1; wait_cyc(1); flt_ack = 1'b0;
        wait_cyc(40);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule